// File: doc/BRIEF.md
# Run-Time Partitioned Lane Equality Comparator

This block compares two data words for equality. Each word is cut into four lanes of equal width. A 3-bit partition control merges neighbouring lanes into wider elements at run time. So one comparator can serve as four narrow compares, two half-width compares, one full-width compare, or any mix of these.

Each lane first forms its own raw match bit. That bit is 1 only when every bit of the lane agrees between the two words. The match bits of all lanes in one element are then ANDed together. The element's result is placed on the output bit of its lowest lane, and the other output bits of that element read 0.

The block is purely combinational, with no clock and no reset.

Top module: `simd_lane_eq`

## Requirements
- R1: The raw match of a lane is 1 only when all LANE_W bits of that lane agree in `lhs` and `rhs`. A single differing bit anywhere in a lane clears it.
- R2: Bit k of `part` (k = 0, 1, 2) set places an element boundary between lane k and lane k+1. Lane 0 holds the least significant bits.
- R3: An element's result is the AND of the raw match bits of all lanes that the element spans.
- R4: An element's result appears on `match` bit of its lowest lane. Every other `match` bit inside the same element is 0, so `match[k]` for k > 0 is 0 whenever `part[k-1]` is clear.
- R5: With `part` = 3'b000, `match[0]` is the AND of all four lane matches, and `match[3:1]` is 0.
- R6: With `part` = 3'b111, each `match[k]` equals lane k's raw match.
- R7: With `part` = 3'b010, `match[0]` is lane0 AND lane1, `match[2]` is lane2 AND lane3, and `match[1]` and `match[3]` are 0.
- R8: With `part` = 3'b100, `match[0]` is the AND of lanes 0 to 2, `match[3]` is lane 3, and `match[1]` and `match[2]` are 0.
- R9: `match` follows any change of the inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs | input | DATA_W | First operand |
| rhs | input | DATA_W | Second operand |
| part | input | 3 | Element boundary bits, bit k splits lane k from lane k+1 |
| match | output | 4 | Per-lane result, valid at the lowest lane of each element |

## Verification
Some rules hold at every moment: the zeroed upper positions of an element, and the exact outputs for the fully merged, fully split and halved codes. The checker tests these rules whenever the inputs settle.

The mixed codes need a broader reference, because a 3-lane element or an element with no boundary at its lowest lane depends on a whole run of lanes. These codes, the detection of single-bit mismatches in each lane, and the same-cycle response are shown only by the bench. It sweeps every partition code against equal, single-lane-corrupted and random operand pairs.

// File: rtl/simd_lane_eq.sv
module simd_lane_eq #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic [2:0]        part,
  output logic [3:0]        match
);
  localparam int LANES  = 4;
  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0] lane_eq;
  logic [LANES-1:0] run_eq;
  logic [LANES-1:0] head;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_eq[k] = (lhs[k*LANE_W +: LANE_W] == rhs[k*LANE_W +: LANE_W]);
    if (k == LANES - 1) begin : g_top
      assign run_eq[k] = lane_eq[k];
    end else begin : g_mid
      assign run_eq[k] = lane_eq[k] & (part[k] | run_eq[k+1]);
    end
    if (k == 0) begin : g_first
      assign head[k] = 1'b1;
    end else begin : g_rest
      assign head[k] = part[k-1];
    end
  end

  assign match = head & run_eq;
endmodule

// File: rtl/simd_lane_eq_chk.sv
module simd_lane_eq_chk #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] lhs,
  input logic [DATA_W-1:0] rhs,
  input logic [2:0]        part,
  input logic [3:0]        match
);
  localparam int LW = DATA_W / 4;

  logic [3:0] leq;
  for (genvar k = 0; k < 4; k++) begin : g_leq
    assign leq[k] = lhs[k*LW +: LW] == rhs[k*LW +: LW];
  end

  always_comb begin
    if (!$isunknown({lhs, rhs, part, match})) begin
      // R4
      upper_zero_chk: assert ((part[0] || !match[1]) && (part[1] || !match[2]) && (part[2] || !match[3]));
      // R5
      merged_chk: assert (part != 3'b000 || match == {3'b000, lhs == rhs});
      // R6
      split_chk: assert (part != 3'b111 || match == leq);
      // R7
      halves_chk: assert (part != 3'b010 || match == {1'b0, leq[3] & leq[2], 1'b0, leq[1] & leq[0]});
      // R3
      low_lane_chk: assert (!match[0] || leq[0]);
    end
  end
endmodule

bind simd_lane_eq simd_lane_eq_chk #(.DATA_W(DATA_W)) u_chk (
  .lhs(lhs), .rhs(rhs), .part(part), .match(match)
);

// File: tb/simd_lane_eq_bench.sv
`timescale 1ns/1ps
module simd_lane_eq_bench;
  localparam int DW = 32;
  localparam int LW = DW / 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [DW-1:0] lhs, rhs;
  logic [2:0]    part;
  logic [3:0]    match;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  simd_lane_eq #(.DATA_W(DW)) u_simd_lane_eq (
    .lhs(lhs), .rhs(rhs), .part(part), .match(match)
  );

  function automatic logic [3:0] model(logic [DW-1:0] a, logic [DW-1:0] b, logic [2:0] p);
    logic [3:0] r = 4'b0000;
    for (int k = 0; k < 4; k++) begin
      if (k == 0 || p[k-1]) begin
        int j = k;
        logic acc = 1'b1;
        while (1) begin
          if (a[j*LW +: LW] != b[j*LW +: LW]) acc = 1'b0;
          if (j == 3 || p[j]) break;
          j++;
        end
        r[k] = acc;
      end
    end
    return r;
  endfunction

  function automatic string tag_for(logic [2:0] p);
    case (p)
      3'b000: return "R5";
      3'b111: return "R6";
      3'b010: return "R7";
      3'b100: return "R8";
      default: return "R3/R4";
    endcase
  endfunction

  task automatic apply(logic [DW-1:0] a, logic [DW-1:0] b, logic [2:0] p, string req);
    logic [3:0] exp;
    @(posedge clk);
    lhs = a; rhs = b; part = p;
    exp = model(a, b, p);
    @(negedge clk);
    checks++;
    if (match !== exp) begin
      errors++;
      $display("FAIL %s part=%b lhs=%h rhs=%h actual=%b expected=%b", req, p, a, b, match, exp);
    end
  endtask

  initial begin
    lhs = '0; rhs = '0; part = '0;
    repeat (2) @(posedge clk);
    apply('0, '0, 3'b000, "R5");
    for (int p = 0; p < 8; p++) begin
      logic [DW-1:0] base = $urandom;
      apply(base, base, 3'(p), tag_for(3'(p)));
      for (int k = 0; k < 4; k++) begin
        apply(base, base ^ (DW'(1) << (k*LW + LW - 1)), 3'(p), tag_for(3'(p)));
        apply(base, base ^ (DW'(1) << (k*LW)), 3'(p), "R2");
      end
      for (int n = 0; n < 6; n++) begin
        logic [DW-1:0] a = $urandom;
        logic [DW-1:0] b = a;
        for (int k = 0; k < 4; k++)
          if ($urandom_range(1, 0) == 1) b[k*LW +: LW] = 8'($urandom);
        apply(a, b, 3'(p), tag_for(3'(p)));
      end
    end
    for (int bit_i = 0; bit_i < DW; bit_i++) begin
      logic [DW-1:0] a = $urandom;
      apply(a, a ^ (DW'(1) << bit_i), 3'b111, "R1");
    end
    // R9: change inputs each cycle and expect the new result on the same cycle
    apply(32'h1122_3344, 32'h1122_3344, 3'b000, "R9");
    apply(32'h1122_3344, 32'h1122_3345, 3'b000, "R9");
    apply(32'h1122_3344, 32'h1122_3345, 3'b001, "R9");
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule